// File: doc/BRIEF.md
# Dual-Mode Hybrid Cache Lookup

This block performs the tag lookup and hit/miss decision of a two-way set-associative second-level cache that runs in one of two modes. In the fast mode, a small on-die array of sets holds tags for lines whose data also sits on-die. In the large mode, the same tag storage is reused with more sets and a narrower tag, and it tags lines held in a large stacked DRAM data array. The address split, the comparator set in use and the data routing all follow the active mode. The choice of mode comes from outside the block.

Each accepted request returns, one cycle later, a hit flag, the way that hit (or the victim way chosen on a miss), and a select that names the data array serving the access. On a miss the requested line is allocated into the victim way, so a later access to the same line hits. The block also drives the power-gate enable of the DRAM array. A mode change empties the cache in a single stall cycle.

Top module: `hybrid_cache_lookup`

## Requirements
- R1: `rsp_valid` is 1 in the cycle after a request is accepted (`req_valid` and `req_ready` both 1 at a clock edge) and 0 after every cycle with no accepted request.
- R2: Address bits [5:0] (line offset) never affect the result. In small mode (`mode_sel`=0) the set index is bits [6+SIDX_W-1:6] and the tag is every bit above it. In large mode (`mode_sel`=1) the set index is bits [6+LIDX_W-1:6] and the tag is every bit above it.
- R3: A miss (`rsp_hit`=0) installs the requested line into the way reported on `rsp_way`. A later access to that line hits in that same way, unless a mode change, a reset or an eviction came in between.
- R4: Each set keeps one LRU bit that names its victim way (0 or 1) and starts at 0. A hit in way w sets the victim to the other way. A miss fills the current victim, reports it on `rsp_way`, and then points the victim at the other way.
- R5: `rsp_sel_dram` is 1 with a response taken in large mode (data from the DRAM array) and 0 with a response taken in small mode (data from the on-die array).
- R6: `dram_pg_en` is 1 (DRAM array gated off) exactly while the active mode is small. It changes only in the cycle after a mode-change stall cycle or on reset.
- R7: When `mode_sel` differs from the active mode, `req_ready` is 0 for exactly that cycle. A request in that cycle is not accepted. At the edge the active mode takes the value of `mode_sel`, and every line and LRU bit is cleared, so the first access to any line afterwards misses.
- R8: A synchronous reset (`rst`=1) holds `req_ready` at 0. It leaves the block in small mode with no valid lines, all LRU bits 0, `rsp_valid`=0 and `dram_pg_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 1 | Requested mode: 0 small on-die cache, 1 large DRAM-backed cache |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | ADDR_W | Physical address of the request |
| req_ready | output | 1 | Block can accept a request this cycle |
| rsp_valid | output | 1 | Response strobe, one cycle after acceptance |
| rsp_hit | output | 1 | 1 on hit, 0 on miss |
| rsp_way | output | 1 | Hitting way, or the victim way that was filled on a miss |
| rsp_sel_dram | output | 1 | Data array select: 1 DRAM array, 0 on-die array |
| dram_pg_en | output | 1 | Power-gate enable of the DRAM data array, 1 gates it off |

## Verification
The hardest state to reach from the ports is a mode change that arrives while the cache holds lines, followed at once by accesses to those same lines. Only this sequence shows that the single-cycle invalidation really cleared them, and that a request in the stall cycle was dropped. The stimulus fills sets in one mode, flips `mode_sel` in the same cycle as a pending request, and re-touches the filled lines in both modes. It also uses address pairs that share a set in small mode but split in large mode. Random traffic from a narrow address pool keeps sets full enough that LRU evictions, hits and occasional mode flips mix with each other.

// File: rtl/hcl_pkg.sv
package hcl_pkg;
  localparam int HCL_WAYS = 2;
  localparam int HCL_WAY_W = 1;

  typedef enum logic {
    MODE_SMALL = 1'b0,
    MODE_LARGE = 1'b1
  } hcl_mode_e;
endpackage

// File: rtl/hcl_addr_split.sv
// Splits the line address (offset already removed) into set index and a
// zero-extended tag of the widest tag width.
module hcl_addr_split #(
  parameter int LINE_W = 58,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 54
) (
  input  logic [LINE_W-1:0] line_addr,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);
  localparam int FLD_W = LINE_W - IDX_W;

  assign idx = line_addr[IDX_W-1:0];

  generate
    if (FLD_W == TAG_W) begin : g_full
      assign tag = line_addr[LINE_W-1:IDX_W];
    end else begin : g_ext
      assign tag = {{(TAG_W-FLD_W){1'b0}}, line_addr[LINE_W-1:IDX_W]};
    end
  endgenerate
endmodule

// File: rtl/hcl_way_cmp.sv
// Per-way tag comparators for one mode.
module hcl_way_cmp #(
  parameter int NWAY  = 2,
  parameter int TAG_W = 54
) (
  input  logic [TAG_W-1:0]            tag_in,
  input  logic [NWAY-1:0][TAG_W-1:0]  set_tags,
  input  logic [NWAY-1:0]             set_vld,
  output logic [NWAY-1:0]             hit_vec
);
  generate
    for (genvar w = 0; w < NWAY; w++) begin : g_way
      assign hit_vec[w] = set_vld[w] && (set_tags[w] == tag_in);
    end
  endgenerate
endmodule

// File: rtl/hcl_tag_store.sv
// Tag memory (one RAM per way, two read ports), valid flags and LRU bits.
module hcl_tag_store #(
  parameter int NWAY  = 2,
  parameter int WAY_W = 1,
  parameter int IDX_W = 6,
  parameter int TAG_W = 54
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       flush,
  input  logic [IDX_W-1:0]           rd_idx_a,
  input  logic [IDX_W-1:0]           rd_idx_b,
  output logic [NWAY-1:0][TAG_W-1:0] rd_tag_a,
  output logic [NWAY-1:0][TAG_W-1:0] rd_tag_b,
  output logic [NWAY-1:0]            rd_vld_a,
  output logic [NWAY-1:0]            rd_vld_b,
  output logic                       rd_lru_a,
  output logic                       rd_lru_b,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [WAY_W-1:0]           wr_way,
  input  logic [TAG_W-1:0]           wr_tag,
  input  logic                       lru_we,
  input  logic [IDX_W-1:0]           lru_idx,
  input  logic                       lru_val
);
  localparam int SETS = 1 << IDX_W;

  generate
    for (genvar w = 0; w < NWAY; w++) begin : g_way
      logic [TAG_W-1:0] tag_mem [SETS];
      logic [SETS-1:0]  vld_q;
      logic             sel_w;

      assign sel_w = wr_en && (wr_way == WAY_W'(w));

      always_ff @(posedge clk) begin
        if (sel_w) tag_mem[wr_idx] <= wr_tag;
      end

      always_ff @(posedge clk) begin
        if (rst || flush) vld_q <= '0;
        else if (sel_w)   vld_q[wr_idx] <= 1'b1;
      end

      assign rd_tag_a[w] = tag_mem[rd_idx_a];
      assign rd_tag_b[w] = tag_mem[rd_idx_b];
      assign rd_vld_a[w] = vld_q[rd_idx_a];
      assign rd_vld_b[w] = vld_q[rd_idx_b];
    end
  endgenerate

  logic [SETS-1:0] lru_q;

  always_ff @(posedge clk) begin
    if (rst || flush) lru_q <= '0;
    else if (lru_we)  lru_q[lru_idx] <= lru_val;
  end

  assign rd_lru_a = lru_q[rd_idx_a];
  assign rd_lru_b = lru_q[rd_idx_b];
endmodule

// File: rtl/hybrid_cache_lookup.sv
module hybrid_cache_lookup #(
  parameter int ADDR_W = 64,
  parameter int OFFS_W = 6,
  parameter int SIDX_W = 4,
  parameter int LIDX_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_sel,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_way,
  output logic              rsp_sel_dram,
  output logic              dram_pg_en
);
  import hcl_pkg::*;

  localparam int LINE_W = ADDR_W - OFFS_W;
  localparam int TAG_W  = LINE_W - SIDX_W;
  localparam int PAD_W  = LIDX_W - SIDX_W;

  hcl_mode_e   cur_mode;
  logic        switching;
  logic        accept;
  logic [LINE_W-1:0] line_addr;

  assign line_addr = req_addr[ADDR_W-1:OFFS_W];
  assign switching = (hcl_mode_e'(mode_sel) != cur_mode);
  assign req_ready = !rst && !switching;
  assign accept    = req_valid && req_ready;

  // Address split per mode
  logic [SIDX_W-1:0] s_idx;
  logic [LIDX_W-1:0] l_idx;
  logic [TAG_W-1:0]  s_tag, l_tag;

  hcl_addr_split #(.LINE_W(LINE_W), .IDX_W(SIDX_W), .TAG_W(TAG_W)) u_split_s (
    .line_addr(line_addr), .idx(s_idx), .tag(s_tag));

  hcl_addr_split #(.LINE_W(LINE_W), .IDX_W(LIDX_W), .TAG_W(TAG_W)) u_split_l (
    .line_addr(line_addr), .idx(l_idx), .tag(l_tag));

  logic [LIDX_W-1:0] s_idx_ext;
  assign s_idx_ext = {{PAD_W{1'b0}}, s_idx};

  // Shared tag storage
  logic [HCL_WAYS-1:0][TAG_W-1:0] tags_s, tags_l;
  logic [HCL_WAYS-1:0] vld_s, vld_l;
  logic lru_s, lru_l;

  logic              wr_en;
  logic [LIDX_W-1:0] act_idx;
  logic [TAG_W-1:0]  act_tag;
  logic              act_victim;
  logic              res_way;

  hcl_tag_store #(
    .NWAY(HCL_WAYS), .WAY_W(HCL_WAY_W), .IDX_W(LIDX_W), .TAG_W(TAG_W)
  ) u_store (
    .clk(clk), .rst(rst), .flush(!rst && switching),
    .rd_idx_a(s_idx_ext), .rd_idx_b(l_idx),
    .rd_tag_a(tags_s), .rd_tag_b(tags_l),
    .rd_vld_a(vld_s), .rd_vld_b(vld_l),
    .rd_lru_a(lru_s), .rd_lru_b(lru_l),
    .wr_en(wr_en), .wr_idx(act_idx), .wr_way(act_victim), .wr_tag(act_tag),
    .lru_we(accept), .lru_idx(act_idx), .lru_val(!res_way)
  );

  // One comparator bank per mode
  logic [HCL_WAYS-1:0] hit_s, hit_l, act_hit;

  hcl_way_cmp #(.NWAY(HCL_WAYS), .TAG_W(TAG_W)) u_cmp_s (
    .tag_in(s_tag), .set_tags(tags_s), .set_vld(vld_s), .hit_vec(hit_s));

  hcl_way_cmp #(.NWAY(HCL_WAYS), .TAG_W(TAG_W)) u_cmp_l (
    .tag_in(l_tag), .set_tags(tags_l), .set_vld(vld_l), .hit_vec(hit_l));

  logic any_hit;

  always_comb begin
    if (cur_mode == MODE_LARGE) begin
      act_hit    = hit_l;
      act_idx    = l_idx;
      act_tag    = l_tag;
      act_victim = lru_l;
    end else begin
      act_hit    = hit_s;
      act_idx    = s_idx_ext;
      act_tag    = s_tag;
      act_victim = lru_s;
    end
    any_hit = |act_hit;
    res_way = any_hit ? act_hit[1] : act_victim;
  end

  assign wr_en = accept && !any_hit;

  // Mode state and registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_mode   <= MODE_SMALL;
      dram_pg_en <= 1'b1;
    end else if (switching) begin
      cur_mode   <= hcl_mode_e'(mode_sel);
      dram_pg_en <= (hcl_mode_e'(mode_sel) == MODE_SMALL);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_hit      <= 1'b0;
      rsp_way      <= 1'b0;
      rsp_sel_dram <= 1'b0;
    end else begin
      rsp_valid <= accept;
      if (accept) begin
        rsp_hit      <= any_hit;
        rsp_way      <= res_way;
        rsp_sel_dram <= (cur_mode == MODE_LARGE);
      end
    end
  end
endmodule

// File: rtl/hcl_checker.sv
module hcl_checker (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic rsp_sel_dram,
  input logic dram_pg_en
);
  // R1
  a_r1_rsp_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  // R1
  a_r1_no_rsp_without_accept: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !rsp_valid);

  // R5
  a_r5_sel_opposes_gate: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_sel_dram == !dram_pg_en));

  // R6
  a_r6_gate_steady_when_ready: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> $stable(dram_pg_en));

  // R7
  a_r7_stall_flips_mode: assert property (@(posedge clk) disable iff (rst)
    !req_ready |=> (dram_pg_en != $past(dram_pg_en)));

  // R8
  a_r8_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && dram_pg_en));
endmodule

bind hybrid_cache_lookup hcl_checker u_chk (.*);

// File: tb/tb_hybrid_cache_lookup.sv
module tb_hybrid_cache_lookup;
  logic        clk = 1'b0;
  logic        rst, mode_sel, req_valid;
  logic [63:0] req_addr;
  logic        req_ready, rsp_valid, rsp_hit, rsp_way, rsp_sel_dram, dram_pg_en;

  always #5 clk = ~clk;

  hybrid_cache_lookup dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .req_valid(req_valid),
    .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_sel_dram(rsp_sel_dram),
    .dram_pg_en(dram_pg_en));

  int errors = 0;
  int checks = 0;

  // Reference model
  logic [63:0] mt [2][64];
  logic        mv [2][64];
  logic        ml [64];
  logic        mode_m;
  logic        pend_v, pend_hit, pend_way, pend_sel;
  bit          started = 0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < 64; s++) begin
      mv[0][s] = 0; mv[1][s] = 0; ml[s] = 0;
    end
  endtask

  task automatic model_access(input logic [63:0] a);
    int idx;
    logic [63:0] tg;
    logic w;
    idx = mode_m ? int'(a[11:6]) : int'(a[9:6]);
    tg  = mode_m ? (a >> 12) : (a >> 10);
    if (mv[0][idx] && mt[0][idx] == tg)      begin pend_hit = 1; w = 0; end
    else if (mv[1][idx] && mt[1][idx] == tg) begin pend_hit = 1; w = 1; end
    else begin
      pend_hit = 0; w = ml[idx];
      mt[w][idx] = tg; mv[w][idx] = 1;
    end
    ml[idx]  = ~w;
    pend_way = w;
    pend_sel = mode_m;
  endtask

  // One cycle: check last edge's results, drive new inputs, predict.
  task automatic step(input logic r, input logic v, input logic [63:0] a,
                      input logic m);
    logic exp_ready;
    if (started) begin
      chk(rsp_valid === pend_v, "R1 rsp_valid", rsp_valid, pend_v);
      if (pend_v) begin
        chk(rsp_hit === pend_hit, "R3 rsp_hit", rsp_hit, pend_hit);
        chk(rsp_way === pend_way, "R4 rsp_way", rsp_way, pend_way);
        chk(rsp_sel_dram === pend_sel, "R5 rsp_sel_dram", rsp_sel_dram, pend_sel);
      end
      chk(dram_pg_en === !mode_m, "R6 dram_pg_en", dram_pg_en, !mode_m);
    end
    rst = r; req_valid = v; req_addr = a; mode_sel = m;
    #1;
    exp_ready = !r && (m == mode_m);
    if (started)
      chk(req_ready === exp_ready, r ? "R8 req_ready in reset" : "R7 req_ready",
          req_ready, exp_ready);
    pend_v = 0;
    if (r) begin
      mode_m = 0; model_clear();
    end else if (m != mode_m) begin
      mode_m = m; model_clear();
    end else if (v) begin
      pend_v = 1;
      model_access(a);
    end
    started = 1;
    @(negedge clk);
  endtask

  task automatic idle(input logic m);
    step(0, 0, 64'h0, m);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    mode_m = 0; pend_v = 0; pend_hit = 0; pend_way = 0; pend_sel = 0;
    model_clear();
    @(negedge clk);
    // R8: reset state
    step(1, 0, 0, 0);
    step(1, 1, 64'h40, 1);
    step(1, 0, 0, 0);
    chk(rsp_valid === 0, "R8 rsp_valid after reset", rsp_valid, 0);
    chk(dram_pg_en === 1, "R8 dram_pg_en after reset", dram_pg_en, 1);

    // R2: offset ignored; small mode set index bits [9:6]
    step(0, 1, 64'h0000_1040, 0);            // miss way0
    step(0, 1, 64'h0000_107F, 0);            // same line: hit way0 (R2)
    idle(0);
    chk(rsp_hit === 1 && rsp_way === 0, "R2 offset ignored hit", {rsp_hit, rsp_way}, 2'b10);

    // R4: A, B, A, C, B in one small set
    step(0, 1, 64'h0000_2080, 0);            // A miss way0
    step(0, 1, 64'h0000_6080, 0);            // B miss way1
    step(0, 1, 64'h0000_2080, 0);            // A hit way0
    step(0, 1, 64'h0001_2080, 0);            // C miss evicts B in way1
    step(0, 1, 64'h0000_6080, 0);            // B miss way0 (A was LRU)
    idle(0);
    chk(rsp_hit === 0 && rsp_way === 0, "R4 B refill way0", {rsp_hit, rsp_way}, 2'b00);

    // R7: mode change with a request in the stall cycle, then re-touch
    step(0, 1, 64'h0000_2080, 1);            // stall, not accepted
    step(0, 1, 64'h0000_2080, 1);            // large mode: miss
    step(0, 1, 64'h0000_2080, 1);            // hit
    idle(1);
    chk(rsp_hit === 1 && rsp_sel_dram === 1, "R5 large hit from DRAM",
        {rsp_hit, rsp_sel_dram}, 2'b11);

    // R2: addresses differing in bit 10 share a small set but split in large
    step(0, 1, 64'h0000_0400, 1);
    step(0, 1, 64'h0000_0000, 1);
    step(0, 1, 64'h0001_0400, 1);            // other tag, large set 16
    step(0, 1, 64'h0000_0400, 1);            // still resident: hit
    step(0, 1, 64'h0000_0000, 1);            // hit
    idle(0);                                  // switch back: flush
    step(0, 1, 64'h0000_0400, 0);            // small: miss after flush
    idle(0);
    chk(rsp_hit === 0, "R7 miss after flush", rsp_hit, 0);

    // Mid-run reset while in large mode
    idle(1); idle(1);
    step(0, 1, 64'h0000_0040, 1);
    step(1, 1, 64'h0000_0040, 1);
    step(0, 1, 64'h0000_0040, 0);            // small mode, empty: miss (R8)
    idle(0);

    // Constrained random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [63:0] a;
      logic m;
      a = (64'($urandom_range(0, 1)) << 16) | (64'($urandom_range(0, 1)) << 10)
        | (64'($urandom_range(0, 3)) << 6) | 64'($urandom_range(0, 63));
      m = ($urandom_range(0, 63) == 0) ? ~mode_m : mode_m;
      step(0, ($urandom_range(0, 3) != 0), a, m);
    end
    idle(mode_m);
    idle(mode_m);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule